// File: doc/BRIEF.md
# Sequential Fixed-Point Ratio Divider

This block turns one complex frequency bin into the ratio of its real part to its imaginary part. That ratio is proportional to the decay constant of an exponential signal. The caller presents two 28-bit two's-complement operands with a one-cycle start pulse. The real part is the dividend and the imaginary part is the divisor. The block takes the magnitude of each operand and runs an iterative unsigned restoring division. It produces a 42-bit quotient: 28 integer bits above 14 fraction bits.

The latency is fixed, whatever the operand values. A done pulse marks the result exactly 32 cycles after start is accepted. The division itself needs fewer cycles: several quotient bits are resolved per cycle, and the control counter pads the remaining cycles. Along with the full quotient, the block packs a 16-bit unsigned word in 3.13 format for a narrow downstream reader, and it saturates that word when the ratio does not fit. A zero divisor raises an error flag. All results stay on the outputs until the next division completes.

Top module: `ratio_divider`

## Requirements
- R1: While reset is asserted and right after it is released, done_o, busy_o and div0_o are 0, and ratio_o and quot_o are 0.
- R2: A start_i sampled high while busy_o is 0 is accepted and sets busy_o from the next cycle. If start_i is sampled at edge E, done_o is 1 in the cycle after edge E+32, and busy_o is 0 in that same cycle.
- R3: A start_i sampled while busy_o is 1 is ignored. The result and the timing still belong to the accepted start.
- R4: quot_o equals floor(|re_i| * 2^14 / |im_i|) as an unsigned 42-bit value. Bits 41..14 hold the integer part and bits 13..0 hold the fraction.
- R5: The signs of both operands are dropped. Operands of either sign, including -2^27, give the quotient of their magnitudes.
- R6: When the integer part of the quotient is below 8 and the divisor is nonzero, ratio_o equals quot_o bits 16..1. This is the 3 low integer bits followed by the 13 high fraction bits, so ratio_o / 2^13 is the ratio.
- R7: When the integer part of the quotient is 8 or more, ratio_o is 16'hFFFF.
- R8: When the divisor is zero, div0_o is 1, ratio_o is 16'hFFFF and quot_o is all ones. Otherwise div0_o is 0 with each result.
- R9: quot_o, ratio_o and div0_o change only in the cycle where done_o is 1, and hold their values in all other cycles.
- R10: done_o is 1 for exactly one cycle per accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse; operands are sampled with it |
| re_i | input | 28 | Dividend, signed real part |
| im_i | input | 28 | Divisor, signed imaginary part |
| busy_o | output | 1 | Division in progress |
| done_o | output | 1 | One-cycle result strobe |
| quot_o | output | 42 | Unsigned quotient magnitude, 28.14 |
| ratio_o | output | 16 | Packed unsigned 3.13 ratio, saturating |
| div0_o | output | 1 | Divisor was zero |

## Verification
A wrong bit in the partial remainder or the shifting quotient register changes every quotient bit resolved after it. quot_o then differs from the reference in the done cycle, 32 cycles after start, and ratio_o often differs too, because it is taken from the low integer bits and the high fraction bits. A corrupted cycle counter or control state shows up as done_o appearing in the wrong cycle, or as busy_o staying high. Since the bench compares every cycle, this is seen within one cycle of the expected completion. A start that leaks into a running division would show a quotient that belongs to the second operand pair.

// File: rtl/ratio_div_pkg.sv
package ratio_div_pkg;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } rdiv_state_e;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

endpackage

// File: rtl/rdiv_operand_mag.sv
module rdiv_operand_mag #(
  parameter int W = 28
) (
  input  logic [W-1:0] val_i,
  output logic [W-1:0] mag_o,
  output logic         zero_o
);

  logic neg;

  always_comb begin
    neg    = val_i[W-1];
    mag_o  = neg ? (~val_i + {{(W-1){1'b0}}, 1'b1}) : val_i;
    zero_o = (val_i == '0);
  end

endmodule

// File: rtl/rdiv_core.sv
module rdiv_core #(
  parameter int W      = 28,
  parameter int FRAC_W = 14,
  parameter int STEPS  = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_i,
  input  logic                step_i,
  input  logic [W-1:0]        num_i,
  input  logic [W-1:0]        den_i,
  output logic [W+FRAC_W-1:0] quot_o
);

  localparam int QW = W + FRAC_W;
  localparam int RW = W + 1;

  logic [QW-1:0] num_q, num_d;
  logic [RW-1:0] rem_q, rem_d;
  logic [W-1:0]  den_q, den_d;

  logic [RW-1:0] rem_c [STEPS+1];
  logic [QW-1:0] num_c [STEPS+1];

  assign rem_c[0] = rem_q;
  assign num_c[0] = num_q;

  for (genvar g = 0; g < STEPS; g++) begin : g_step
    logic [RW-1:0] trial;
    logic          fits;
    assign trial        = {rem_c[g][RW-2:0], num_c[g][QW-1]};
    assign fits         = (trial >= {1'b0, den_q});
    assign rem_c[g+1]   = fits ? (trial - {1'b0, den_q}) : trial;
    assign num_c[g+1]   = {num_c[g][QW-2:0], fits};
  end

  always_comb begin
    num_d = num_q;
    rem_d = rem_q;
    den_d = den_q;
    if (load_i) begin
      num_d = {num_i, {FRAC_W{1'b0}}};
      rem_d = '0;
      den_d = den_i;
    end else if (step_i) begin
      num_d = num_c[STEPS];
      rem_d = rem_c[STEPS];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      num_q <= '0;
      rem_q <= '0;
      den_q <= '0;
    end else if (load_i || step_i) begin
      num_q <= num_d;
      rem_q <= rem_d;
      den_q <= den_d;
    end
  end

  assign quot_o = num_q;

endmodule

// File: rtl/rdiv_pack.sv
module rdiv_pack #(
  parameter int W        = 28,
  parameter int FRAC_W   = 14,
  parameter int OUT_INT  = 3,
  parameter int OUT_FRAC = 13
) (
  input  logic [W+FRAC_W-1:0]       quot_i,
  input  logic                      div0_i,
  output logic [OUT_INT+OUT_FRAC-1:0] word_o
);

  localparam int QW  = W + FRAC_W;
  localparam int OW  = OUT_INT + OUT_FRAC;
  localparam int LSB = FRAC_W - OUT_FRAC;
  localparam int TOP = FRAC_W + OUT_INT;

  logic overflow;

  always_comb begin
    overflow = (quot_i[QW-1:TOP] != '0);
    if (div0_i || overflow) begin
      word_o = {OW{1'b1}};
    end else begin
      word_o = quot_i[TOP-1:LSB];
    end
  end

endmodule

// File: rtl/ratio_divider.sv
module ratio_divider
  import ratio_div_pkg::*;
#(
  parameter int W        = 28,
  parameter int FRAC_W   = 14,
  parameter int LATENCY  = 32,
  parameter int STEPS    = 2,
  parameter int OUT_INT  = 3,
  parameter int OUT_FRAC = 13
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start_i,
  input  logic [W-1:0]                 re_i,
  input  logic [W-1:0]                 im_i,
  output logic                         busy_o,
  output logic                         done_o,
  output logic [W+FRAC_W-1:0]          quot_o,
  output logic [OUT_INT+OUT_FRAC-1:0]  ratio_o,
  output logic                         div0_o
);

  localparam int QW    = W + FRAC_W;
  localparam int OW    = OUT_INT + OUT_FRAC;
  localparam int ITER  = ceil_div(QW, STEPS);
  localparam int CNT_W = $clog2(LATENCY + 1);
  localparam logic [CNT_W-1:0] ITER_C = CNT_W'(ITER);
  localparam logic [CNT_W-1:0] LAT_C  = CNT_W'(LATENCY);

  rdiv_state_e      state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             zden_q, zden_d;

  logic [W-1:0]     re_mag, im_mag;
  logic             re_zero, im_zero;
  logic [QW-1:0]    core_quot;
  logic [OW-1:0]    packed_word;

  logic             accept, step, finish;

  logic [QW-1:0]    quot_q;
  logic [OW-1:0]    ratio_q;
  logic             div0_q;
  logic             done_q, done_d;

  rdiv_operand_mag #(.W(W)) u_mag_re (
    .val_i (re_i),
    .mag_o (re_mag),
    .zero_o(re_zero)
  );

  rdiv_operand_mag #(.W(W)) u_mag_im (
    .val_i (im_i),
    .mag_o (im_mag),
    .zero_o(im_zero)
  );

  rdiv_core #(.W(W), .FRAC_W(FRAC_W), .STEPS(STEPS)) u_core (
    .clk   (clk),
    .rst_n (rst_n),
    .load_i(accept),
    .step_i(step),
    .num_i (re_mag),
    .den_i (im_mag),
    .quot_o(core_quot)
  );

  rdiv_pack #(.W(W), .FRAC_W(FRAC_W), .OUT_INT(OUT_INT), .OUT_FRAC(OUT_FRAC)) u_pack (
    .quot_i(core_quot),
    .div0_i(zden_q),
    .word_o(packed_word)
  );

  always_comb begin
    accept  = start_i && (state_q == ST_IDLE);
    step    = (state_q == ST_RUN) && (cnt_q <= ITER_C);
    finish  = (state_q == ST_RUN) && (cnt_q == LAT_C);
    state_d = state_q;
    cnt_d   = cnt_q;
    zden_d  = zden_q;
    done_d  = 1'b0;
    if (accept) begin
      state_d = ST_RUN;
      cnt_d   = {{(CNT_W-1){1'b0}}, 1'b1};
      zden_d  = im_zero;
    end else if (finish) begin
      state_d = ST_IDLE;
      cnt_d   = '0;
      done_d  = 1'b1;
    end else if (state_q == ST_RUN) begin
      cnt_d   = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      zden_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      zden_q  <= zden_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quot_q  <= '0;
      ratio_q <= '0;
      div0_q  <= 1'b0;
    end else if (finish) begin
      quot_q  <= core_quot;
      ratio_q <= packed_word;
      div0_q  <= zden_q;
    end
  end

  assign busy_o  = (state_q == ST_RUN);
  assign done_o  = done_q;
  assign quot_o  = quot_q;
  assign ratio_o = ratio_q;
  assign div0_o  = div0_q;

  logic unused_re_zero;
  assign unused_re_zero = re_zero;

endmodule

// File: rtl/ratio_divider_chk.sv
module ratio_divider_chk #(
  parameter int W        = 28,
  parameter int FRAC_W   = 14,
  parameter int LATENCY  = 32,
  parameter int OUT_INT  = 3,
  parameter int OUT_FRAC = 13
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        start_i,
  input logic                        busy_o,
  input logic                        done_o,
  input logic [W+FRAC_W-1:0]         quot_o,
  input logic [OUT_INT+OUT_FRAC-1:0] ratio_o,
  input logic                        div0_o
);

  localparam int LW  = $clog2(LATENCY + 2);
  localparam int TOP = FRAC_W + OUT_INT;

  logic [LW-1:0] lat_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_cnt <= '0;
    end else if (start_i && !busy_o) begin
      lat_cnt <= '0;
    end else if (busy_o) begin
      lat_cnt <= lat_cnt + 1'b1;
    end
  end

  assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);

  assert_done_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (lat_cnt == LW'(LATENCY)) && !busy_o);

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_div0_sat_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && div0_o) |-> (ratio_o == '1) && (quot_o == '1));

  assert_overflow_sat_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && (quot_o[W+FRAC_W-1:TOP] != '0)) |-> (ratio_o == '1));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(quot_o) && $stable(ratio_o) && $stable(div0_o)));

endmodule

bind ratio_divider ratio_divider_chk #(
  .W(W), .FRAC_W(FRAC_W), .LATENCY(LATENCY), .OUT_INT(OUT_INT), .OUT_FRAC(OUT_FRAC)
) chk_i (
  .clk    (clk),
  .rst_n  (rst_n),
  .start_i(start_i),
  .busy_o (busy_o),
  .done_o (done_o),
  .quot_o (quot_o),
  .ratio_o(ratio_o),
  .div0_o (div0_o)
);

// File: tb/ratio_divider_tb_top.sv
module ratio_divider_tb_top;

  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic [27:0] re_i;
  logic [27:0] im_i;
  logic        busy_o;
  logic        done_o;
  logic [41:0] quot_o;
  logic [15:0] ratio_o;
  logic        div0_o;

  int n_chk;
  int n_fail;
  bit compare_on;

  ratio_divider dut_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(start_i),
    .re_i   (re_i),
    .im_i   (im_i),
    .busy_o (busy_o),
    .done_o (done_o),
    .quot_o (quot_o),
    .ratio_o(ratio_o),
    .div0_o (div0_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // behavioural reference
  bit          m_busy, m_done, m_err, p_err;
  int          m_cnt;
  logic [41:0] m_quot, p_quot;
  logic [15:0] m_ratio, p_ratio;

  function automatic longint mag(input logic [27:0] v);
    longint s;
    s = longint'($signed(v));
    return (s < 0) ? -s : s;
  endfunction

  task automatic calc(input logic [27:0] a, input logic [27:0] b,
                      output logic [41:0] q, output logic [15:0] r, output bit e);
    longint ma, mb, qq;
    ma = mag(a);
    mb = mag(b);
    if (mb == 0) begin
      q = '1; r = 16'hFFFF; e = 1'b1;
    end else begin
      qq = (ma << 14) / mb;
      q = qq[41:0];
      e = 1'b0;
      r = ((qq >> 14) >= 8) ? 16'hFFFF : qq[16:1];
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_err = 0; m_cnt = 0;
      m_quot = '0; m_ratio = '0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        if (m_cnt == 32) begin
          m_done = 1; m_busy = 0;
          m_quot = p_quot; m_ratio = p_ratio; m_err = p_err;
        end else m_cnt++;
      end else if (start_i) begin
        m_busy = 1; m_cnt = 1;
        calc(re_i, im_i, p_quot, p_ratio, p_err);
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (compare_on && rst_n) begin
      check(done_o == m_done, "R2 R10", "done", done_o, m_done);
      check(busy_o == m_busy, "R2", "busy", busy_o, m_busy);
      check(quot_o == m_quot, "R4", "quot", quot_o, m_quot);
      check(div0_o == m_err, "R8", "div0", div0_o, m_err);
      check(ratio_o == m_ratio,
            m_err ? "R8" : (m_ratio == 16'hFFFF ? "R7" : "R6"),
            "ratio", ratio_o, m_ratio);
    end
  end

  task automatic go(input longint a, input longint b);
    @(negedge clk);
    start_i = 1'b1; re_i = a[27:0]; im_i = b[27:0];
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (done_o) break;
    end
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0; compare_on = 0;
    start_i = 0; re_i = '0; im_i = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R1 reset values during reset
    check(!done_o && !busy_o && !div0_o && ratio_o == 0 && quot_o == 0,
          "R1", "reset outputs", {ratio_o, done_o, busy_o}, 0);
    rst_n = 1;
    @(negedge clk);
    check(!done_o && !busy_o && ratio_o == 0 && quot_o == 0,
          "R1", "after release", {ratio_o, busy_o}, 0);
    compare_on = 1;

    // R6 ratio exactly one -> 0x2000
    go(100000, 100000); wait_done();
    check(ratio_o == 16'h2000, "R6", "unit ratio", ratio_o, 16'h2000);
    // R4 fractional quotient
    go(1, 3); wait_done();
    check(quot_o == 42'd5461, "R4", "one third", quot_o, 5461);
    // R5 signs dropped
    go(-300000, 120000); wait_done();
    check(quot_o == 42'd40960, "R5", "neg dividend", quot_o, 40960);
    go(300000, -120000); wait_done();
    check(ratio_o == 16'h5000, "R5", "neg divisor", ratio_o, 16'h5000);
    // R6 just below 8
    go(8*4096 - 1, 4096); wait_done();
    check(ratio_o != 16'hFFFF, "R6", "below saturation", ratio_o, 0);
    // R7 exactly 8 and extreme operand
    go(8*5000, 5000); wait_done();
    check(ratio_o == 16'hFFFF, "R7", "ratio eight", ratio_o, 16'hFFFF);
    go(-134217728, 1); wait_done();
    check(quot_o == (42'd134217728 << 14), "R5", "most negative", quot_o, 0);
    // R8 zero divisor
    go(12345, 0); wait_done();
    check(div0_o && ratio_o == 16'hFFFF, "R8", "zero divisor", ratio_o, 16'hFFFF);
    go(7, 5); wait_done();
    check(!div0_o, "R8", "error cleared", div0_o, 0);
    // R3 start while busy ignored
    @(negedge clk); start_i = 1; re_i = 28'd1000; im_i = 28'd500;
    @(negedge clk); start_i = 0;
    repeat (5) @(negedge clk);
    start_i = 1; re_i = 28'd3; im_i = 28'd1000;
    @(negedge clk); start_i = 0;
    wait_done();
    check(quot_o == 42'd32768, "R3", "second start ignored", quot_o, 32768);
    // R9 hold while idle
    repeat (20) @(negedge clk);
    check(quot_o == 42'd32768 && !done_o, "R9", "held result", quot_o, 32768);
    // back-to-back start in done cycle
    go(50, 70); wait_done();
    start_i = 1; re_i = 28'd70; im_i = 28'd50;
    @(negedge clk); start_i = 0;
    check(busy_o, "R2", "accept at done cycle", busy_o, 1);
    wait_done();
    // sweep of patterns
    for (int k = 1; k < 40; k++) begin
      go(k * 9973 - 200000, (k % 7 == 0) ? 0 : k * 5171 + 13);
      wait_done();
    end
    repeat (5) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule